// File: doc/BRIEF.md
# Static Memory Strobe Timing Generator

This block turns single read or write requests from an internal client into the strobe waveforms of an external asynchronous memory such as a NAND, NOR or pseudo-static RAM device. Every access runs for a programmed number of clock cycles. Within that window, three active-low strobes each open and close at their own programmed times: write enable, output (read) enable and the chip select of the addressed device.

Timing comes from per-chip-select configuration inputs. Each strobe has a setup count, which is the count value at which it asserts, and a pulse count, which is how many counts it stays low. Its hold time is whatever remains of the cycle length. Chip-select timing is programmed separately for reads and for writes. A read can be followed by a programmable number of bus turnaround cycles before the next request is taken. Read data is latched on the clock edge at which the read strobe releases. A single-cycle completion pulse marks the end of every access.

Top module: `xmem_timing_gen`

## Requirements
- R1: After reset, every bit of mem_cs_n, mem_we_n and mem_oe_n is 1, and mem_dout_en, done and rdata are 0. ready is 1.
- R2: A request is taken at a rising edge where req_valid and ready are both 1. ready is 1 only while the block is idle. A req_valid seen while ready is 0 has no effect on any output.
- R3: In a write, access count k runs from 0 in the first cycle after acceptance. mem_we_n is 0 exactly in the counts k with setup <= k < setup + pulse, using the write-enable fields of the addressed chip select.
- R4: In a read, mem_oe_n is 0 exactly in the counts k with setup <= k < setup + pulse, using the read-enable fields of the addressed chip select.
- R5: Only mem_cs_n[req_cs] can go low. It follows the same window rule, using the chip-select write fields for writes and the chip-select read fields for reads.
- R6: An access lasts L counts, where L is the write or read length field and a length of 0 counts as 1. done is 1 for exactly one cycle, the cycle after count L-1.
- R7: A strobe whose setup + pulse exceeds L releases when the access ends, with no strobe active after count L-1.
- R8: rdata takes mem_din at the rising edge where mem_oe_n goes from 0 to 1. A read whose read strobe never asserts leaves rdata unchanged.
- R9: After a read, ready stays 0 for the programmed float count of cycles after the access ends. After a write, or with a float count of 0, ready is 1 in the cycle done is 1.
- R10: During a write access, mem_dout_en is 1 for all L counts and mem_dout holds the accepted write data. mem_addr holds the accepted address from acceptance until the next acceptance.
- R11: Each chip select uses its own timing fields. Field i of every configuration input occupies bits [i*CNT_W +: CNT_W].
- R12: A request held valid when an access without float cycles completes is taken at the edge that ends the done cycle, so accesses run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | CS_W | Target chip select |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| ready | output | 1 | Idle, request can be taken |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Latched read data |
| cfg_we_setup | input | NUM_CS*CNT_W | Write-enable setup per chip select |
| cfg_we_pulse | input | NUM_CS*CNT_W | Write-enable pulse per chip select |
| cfg_cswr_setup | input | NUM_CS*CNT_W | Chip-select setup for writes |
| cfg_cswr_pulse | input | NUM_CS*CNT_W | Chip-select pulse for writes |
| cfg_oe_setup | input | NUM_CS*CNT_W | Read-enable setup |
| cfg_oe_pulse | input | NUM_CS*CNT_W | Read-enable pulse |
| cfg_csrd_setup | input | NUM_CS*CNT_W | Chip-select setup for reads |
| cfg_csrd_pulse | input | NUM_CS*CNT_W | Chip-select pulse for reads |
| cfg_wr_len | input | NUM_CS*CNT_W | Write cycle length |
| cfg_rd_len | input | NUM_CS*CNT_W | Read cycle length |
| cfg_rd_float | input | NUM_CS*CNT_W | Turnaround cycles after a read |
| mem_cs_n | output | NUM_CS | Chip selects, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Read enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dout | output | DATA_W | Write data to memory |
| mem_dout_en | output | 1 | Data bus drive enable |
| mem_din | input | DATA_W | Read data from memory |

## Verification
The completion pulse of one access and the acceptance of the next can fall in the same cycle. The bench provokes this by holding req_valid high across several consecutive writes and reads with a float count of 0. Its cycle-accurate model then shows whether the new access's strobes begin in the cycle directly after done and whether the strobes of the finished access stay released. The release of the read strobe at the forced end of a clipped read, which is also the rdata capture edge, falls in the same cycle as the final count. The bench covers this with a read whose pulse runs past its length, and compares rdata against the mem_din value the model sampled at that edge.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ACCESS = 2'd1,
      ST_FLOAT  = 2'd2
   } xmem_state_e;

   // strobe window indices
   localparam int WIN_WE  = 0;
   localparam int WIN_OE  = 1;
   localparam int WIN_CS  = 2;
   localparam int NUM_WIN = 3;

endpackage

// File: rtl/xmem_cfg_mux.sv
module xmem_cfg_mux #(
   parameter int NUM_CS = 2,
   parameter int CNT_W  = 6,
   localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
   localparam int VEC_W = NUM_CS * CNT_W
) (
   input  logic [CS_W-1:0]  sel,
   input  logic [VEC_W-1:0] v_we_setup,
   input  logic [VEC_W-1:0] v_we_pulse,
   input  logic [VEC_W-1:0] v_cswr_setup,
   input  logic [VEC_W-1:0] v_cswr_pulse,
   input  logic [VEC_W-1:0] v_oe_setup,
   input  logic [VEC_W-1:0] v_oe_pulse,
   input  logic [VEC_W-1:0] v_csrd_setup,
   input  logic [VEC_W-1:0] v_csrd_pulse,
   input  logic [VEC_W-1:0] v_wr_len,
   input  logic [VEC_W-1:0] v_rd_len,
   input  logic [VEC_W-1:0] v_rd_float,
   output logic [CNT_W-1:0] we_setup,
   output logic [CNT_W-1:0] we_pulse,
   output logic [CNT_W-1:0] cswr_setup,
   output logic [CNT_W-1:0] cswr_pulse,
   output logic [CNT_W-1:0] oe_setup,
   output logic [CNT_W-1:0] oe_pulse,
   output logic [CNT_W-1:0] csrd_setup,
   output logic [CNT_W-1:0] csrd_pulse,
   output logic [CNT_W-1:0] wr_len,
   output logic [CNT_W-1:0] rd_len,
   output logic [CNT_W-1:0] rd_float
);

   function automatic logic [CNT_W-1:0] pick(input logic [VEC_W-1:0] v,
                                             input logic [CS_W-1:0]  s);
      return v[int'(s)*CNT_W +: CNT_W];
   endfunction

   always_comb begin
      we_setup   = pick(v_we_setup,   sel);
      we_pulse   = pick(v_we_pulse,   sel);
      cswr_setup = pick(v_cswr_setup, sel);
      cswr_pulse = pick(v_cswr_pulse, sel);
      oe_setup   = pick(v_oe_setup,   sel);
      oe_pulse   = pick(v_oe_pulse,   sel);
      csrd_setup = pick(v_csrd_setup, sel);
      csrd_pulse = pick(v_csrd_pulse, sel);
      wr_len     = pick(v_wr_len,     sel);
      rd_len     = pick(v_rd_len,     sel);
      rd_float   = pick(v_rd_float,   sel);
   end

endmodule

// File: rtl/xmem_strobe_win.sv
module xmem_strobe_win #(
   parameter int CNT_W = 6,
   localparam int SUM_W = CNT_W + 1
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] setup,
   input  logic [CNT_W-1:0] pulse,
   output logic             active
);

   logic [SUM_W-1:0] stop_at;
   logic [SUM_W-1:0] cnt_x;

   always_comb begin
      stop_at = {1'b0, setup} + {1'b0, pulse};
      cnt_x   = {1'b0, cnt};
      active  = (cnt >= setup) && (cnt_x < stop_at);
   end

endmodule

// File: rtl/xmem_timing_gen.sv
module xmem_timing_gen #(
   parameter int NUM_CS = 2,
   parameter int CNT_W  = 6,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
   localparam int VEC_W = NUM_CS * CNT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [CS_W-1:0]   req_cs,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              ready,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   input  logic [VEC_W-1:0]  cfg_we_setup,
   input  logic [VEC_W-1:0]  cfg_we_pulse,
   input  logic [VEC_W-1:0]  cfg_cswr_setup,
   input  logic [VEC_W-1:0]  cfg_cswr_pulse,
   input  logic [VEC_W-1:0]  cfg_oe_setup,
   input  logic [VEC_W-1:0]  cfg_oe_pulse,
   input  logic [VEC_W-1:0]  cfg_csrd_setup,
   input  logic [VEC_W-1:0]  cfg_csrd_pulse,
   input  logic [VEC_W-1:0]  cfg_wr_len,
   input  logic [VEC_W-1:0]  cfg_rd_len,
   input  logic [VEC_W-1:0]  cfg_rd_float,
   output logic [NUM_CS-1:0] mem_cs_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dout,
   output logic              mem_dout_en,
   input  logic [DATA_W-1:0] mem_din
);
   import xmem_pkg::*;

   // elaboration-time parameter checks
   if (NUM_CS < 2 || (1 << CS_W) != NUM_CS) begin : g_bad_cs
      $error("NUM_CS must be a power of two, at least 2");
   end
   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt
      $error("CNT_W must lie in 2..16");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_bus
      $error("bus widths must be positive");
   end

   xmem_state_e       state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  flt_q;
   logic [CS_W-1:0]   cs_q;
   logic              wr_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rdata_q;
   logic              done_q;
   logic              we_n_q;
   logic              oe_n_q;
   logic              dout_en_q;
   logic [NUM_CS-1:0] cs_n_q;

   logic              idle;
   logic              accept;
   logic [CS_W-1:0]   sel_cs;
   logic              sel_wr;
   logic [CNT_W-1:0]  t_we_s, t_we_p, t_cw_s, t_cw_p, t_oe_s, t_oe_p;
   logic [CNT_W-1:0]  t_cr_s, t_cr_p, t_wlen, t_rlen, t_flt;
   logic [CNT_W-1:0]  len_eff;
   logic              last;
   logic              run_nxt;
   logic [CNT_W-1:0]  cnt_nxt;
   logic [CNT_W-1:0]  win_setup [NUM_WIN];
   logic [CNT_W-1:0]  win_pulse [NUM_WIN];
   logic [NUM_WIN-1:0] win_act;
   logic              we_nxt, oe_nxt, cs_nxt;

   assign idle   = (state_q == ST_IDLE);
   assign accept = idle && req_valid;
   assign sel_cs = idle ? req_cs    : cs_q;
   assign sel_wr = idle ? req_write : wr_q;

   xmem_cfg_mux #(.NUM_CS(NUM_CS), .CNT_W(CNT_W)) u_cfg (
      .sel          (sel_cs),
      .v_we_setup   (cfg_we_setup),
      .v_we_pulse   (cfg_we_pulse),
      .v_cswr_setup (cfg_cswr_setup),
      .v_cswr_pulse (cfg_cswr_pulse),
      .v_oe_setup   (cfg_oe_setup),
      .v_oe_pulse   (cfg_oe_pulse),
      .v_csrd_setup (cfg_csrd_setup),
      .v_csrd_pulse (cfg_csrd_pulse),
      .v_wr_len     (cfg_wr_len),
      .v_rd_len     (cfg_rd_len),
      .v_rd_float   (cfg_rd_float),
      .we_setup     (t_we_s),
      .we_pulse     (t_we_p),
      .cswr_setup   (t_cw_s),
      .cswr_pulse   (t_cw_p),
      .oe_setup     (t_oe_s),
      .oe_pulse     (t_oe_p),
      .csrd_setup   (t_cr_s),
      .csrd_pulse   (t_cr_p),
      .wr_len       (t_wlen),
      .rd_len       (t_rlen),
      .rd_float     (t_flt)
   );

   // cycle length, with zero taken as one
   always_comb begin
      len_eff = sel_wr ? t_wlen : t_rlen;
      if (len_eff == '0) len_eff = CNT_W'(1);
   end

   assign last    = (state_q == ST_ACCESS) && (cnt_q == len_eff - CNT_W'(1));
   assign run_nxt = accept || ((state_q == ST_ACCESS) && !last);
   assign cnt_nxt = accept ? '0 : cnt_q + CNT_W'(1);

   always_comb begin
      win_setup[WIN_WE] = t_we_s;
      win_pulse[WIN_WE] = t_we_p;
      win_setup[WIN_OE] = t_oe_s;
      win_pulse[WIN_OE] = t_oe_p;
      win_setup[WIN_CS] = sel_wr ? t_cw_s : t_cr_s;
      win_pulse[WIN_CS] = sel_wr ? t_cw_p : t_cr_p;
   end

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      xmem_strobe_win #(.CNT_W(CNT_W)) u_win (
         .cnt    (cnt_nxt),
         .setup  (win_setup[w]),
         .pulse  (win_pulse[w]),
         .active (win_act[w])
      );
   end

   assign we_nxt = run_nxt &&  sel_wr && win_act[WIN_WE];
   assign oe_nxt = run_nxt && !sel_wr && win_act[WIN_OE];
   assign cs_nxt = run_nxt && win_act[WIN_CS];

   // access sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         flt_q   <= '0;
         cs_q    <= '0;
         wr_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= last;
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  state_q <= ST_ACCESS;
                  cnt_q   <= '0;
                  cs_q    <= req_cs;
                  wr_q    <= req_write;
                  addr_q  <= req_addr;
                  wdata_q <= req_wdata;
               end
            end
            ST_ACCESS: begin
               if (last) begin
                  if (!wr_q && t_flt != '0) begin
                     state_q <= ST_FLOAT;
                     flt_q   <= t_flt;
                  end else begin
                     state_q <= ST_IDLE;
                  end
               end else begin
                  cnt_q <= cnt_nxt;
               end
            end
            ST_FLOAT: begin
               if (flt_q == CNT_W'(1)) state_q <= ST_IDLE;
               flt_q <= flt_q - CNT_W'(1);
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // registered strobes and read capture
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_n_q    <= 1'b1;
         oe_n_q    <= 1'b1;
         dout_en_q <= 1'b0;
         rdata_q   <= '0;
      end else begin
         we_n_q    <= !we_nxt;
         oe_n_q    <= !oe_nxt;
         dout_en_q <= run_nxt && sel_wr;
         if (!oe_n_q && !oe_nxt) rdata_q <= mem_din;
      end
   end

   for (genvar c = 0; c < NUM_CS; c++) begin : g_cs
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cs_n_q[c] <= 1'b1;
         else        cs_n_q[c] <= !(cs_nxt && (sel_cs == CS_W'(c)));
      end
   end

   assign ready       = idle;
   assign done        = done_q;
   assign rdata       = rdata_q;
   assign mem_cs_n    = cs_n_q;
   assign mem_we_n    = we_n_q;
   assign mem_oe_n    = oe_n_q;
   assign mem_addr    = addr_q;
   assign mem_dout    = wdata_q;
   assign mem_dout_en = dout_en_q;

   // R6
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5
   cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~mem_cs_n));

   // R3
   we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_we_n && !mem_oe_n));

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (mem_we_n && mem_oe_n && (&mem_cs_n) && !mem_dout_en));

   // R10
   we_in_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_dout_en);

   // R9
   done_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(state_q == ST_ACCESS));

endmodule

// File: tb/xmem_timing_gen_tb.sv
module xmem_timing_gen_tb;
   localparam int NUM_CS = 2;
   localparam int CNT_W  = 6;
   localparam int ADDR_W = 16;
   localparam int DATA_W = 16;
   localparam int CS_W   = 1;
   localparam int VEC_W  = NUM_CS * CNT_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [CS_W-1:0]   req_cs = '0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic ready, done;
   logic [DATA_W-1:0] rdata;
   logic [VEC_W-1:0] c_ws = '0, c_wp = '0, c_cws = '0, c_cwp = '0;
   logic [VEC_W-1:0] c_rs = '0, c_rp = '0, c_crs = '0, c_crp = '0;
   logic [VEC_W-1:0] c_wl = '0, c_rl = '0, c_fl = '0;
   logic [NUM_CS-1:0] mem_cs_n;
   logic mem_we_n, mem_oe_n, mem_dout_en;
   logic [ADDR_W-1:0] mem_addr;
   logic [DATA_W-1:0] mem_dout;
   logic [DATA_W-1:0] mem_din = 16'h0101;

   int n_vec = 0, n_bad = 0, cyc = 0;

   always #5 clk = ~clk;

   xmem_timing_gen #(.NUM_CS(NUM_CS), .CNT_W(CNT_W), .ADDR_W(ADDR_W),
                     .DATA_W(DATA_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata),
      .ready(ready), .done(done), .rdata(rdata),
      .cfg_we_setup(c_ws), .cfg_we_pulse(c_wp),
      .cfg_cswr_setup(c_cws), .cfg_cswr_pulse(c_cwp),
      .cfg_oe_setup(c_rs), .cfg_oe_pulse(c_rp),
      .cfg_csrd_setup(c_crs), .cfg_csrd_pulse(c_crp),
      .cfg_wr_len(c_wl), .cfg_rd_len(c_rl), .cfg_rd_float(c_fl),
      .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
      .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
      .mem_din(mem_din)
   );

   // ---------------- reference model ----------------
   int m_st = 0;               // 0 idle, 1 access, 2 float
   int m_cnt = 0, m_fl = 0, m_cs = 0, m_wr = 0;
   int t_ws, t_wp, t_cs_s, t_cs_p, t_rs, t_rp, t_len, t_fl;
   int m_addr = 0, m_wd = 0, m_rd = 0, m_done = 0;

   function automatic int fld(input logic [VEC_W-1:0] v, input int c);
      return int'(v[c*CNT_W +: CNT_W]);
   endfunction

   function automatic bit win(input int k, input int s, input int p);
      return (k >= s) && (k < s + p);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_fl = 0; m_done = 0; m_rd = 0;
         m_addr = 0; m_wd = 0;
      end else begin
         m_done = 0;
         if (m_st == 1) begin
            if (!m_wr && win(m_cnt, t_rs, t_rp) &&
                !((m_cnt != t_len - 1) && win(m_cnt + 1, t_rs, t_rp)))
               m_rd = int'(mem_din);
            if (m_cnt == t_len - 1) begin
               m_done = 1;
               if (!m_wr && t_fl > 0) begin m_st = 2; m_fl = t_fl; end
               else m_st = 0;
            end else m_cnt++;
         end else if (m_st == 2) begin
            m_fl--;
            if (m_fl == 0) m_st = 0;
         end else if (req_valid) begin
            m_st = 1; m_cnt = 0; m_cs = int'(req_cs); m_wr = int'(req_write);
            m_addr = int'(req_addr); m_wd = int'(req_wdata);
            t_ws = fld(c_ws, m_cs); t_wp = fld(c_wp, m_cs);
            t_rs = fld(c_rs, m_cs); t_rp = fld(c_rp, m_cs);
            t_cs_s = m_wr ? fld(c_cws, m_cs) : fld(c_crs, m_cs);
            t_cs_p = m_wr ? fld(c_cwp, m_cs) : fld(c_crp, m_cs);
            t_len = m_wr ? fld(c_wl, m_cs) : fld(c_rl, m_cs);
            if (t_len == 0) t_len = 1;
            t_fl = fld(c_fl, m_cs);
         end
      end
   end

   task automatic chk(input string req, input string what,
                      input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h (t=%0t)",
                  req, what, act, exp, $time);
      end
   endtask

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         bit acc;
         int e_cs;
         acc = (m_st == 1);
         e_cs = (1 << NUM_CS) - 1;
         if (acc && win(m_cnt, t_cs_s, t_cs_p)) e_cs = e_cs & ~(1 << m_cs);
         chk("R3", "mem_we_n", int'(mem_we_n),
             (acc && m_wr && win(m_cnt, t_ws, t_wp)) ? 0 : 1);
         chk("R4", "mem_oe_n", int'(mem_oe_n),
             (acc && !m_wr && win(m_cnt, t_rs, t_rp)) ? 0 : 1);
         chk("R5", "mem_cs_n", int'(mem_cs_n), e_cs);
         chk("R6", "done", int'(done), m_done);
         chk("R9", "ready", int'(ready), (m_st == 0) ? 1 : 0);
         chk("R10", "mem_dout_en", int'(mem_dout_en), (acc && m_wr) ? 1 : 0);
         chk("R10", "mem_addr", int'(mem_addr), m_addr);
         if (acc && m_wr) chk("R10", "mem_dout", int'(mem_dout), m_wd);
         chk("R8", "rdata", int'(rdata), m_rd);
      end
   end

   // changing memory read data
   always @(negedge clk) mem_din <= mem_din + 16'h1357;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_bad++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   task automatic set_cfg(input int c, input int ws, input int wp,
                          input int cws, input int cwp, input int rs,
                          input int rp, input int crs, input int crp,
                          input int wl, input int rl, input int fl);
      c_ws[c*CNT_W +: CNT_W]  = CNT_W'(ws);
      c_wp[c*CNT_W +: CNT_W]  = CNT_W'(wp);
      c_cws[c*CNT_W +: CNT_W] = CNT_W'(cws);
      c_cwp[c*CNT_W +: CNT_W] = CNT_W'(cwp);
      c_rs[c*CNT_W +: CNT_W]  = CNT_W'(rs);
      c_rp[c*CNT_W +: CNT_W]  = CNT_W'(rp);
      c_crs[c*CNT_W +: CNT_W] = CNT_W'(crs);
      c_crp[c*CNT_W +: CNT_W] = CNT_W'(crp);
      c_wl[c*CNT_W +: CNT_W]  = CNT_W'(wl);
      c_rl[c*CNT_W +: CNT_W]  = CNT_W'(rl);
      c_fl[c*CNT_W +: CNT_W]  = CNT_W'(fl);
   endtask

   // present a request and hold it until the edge that takes it
   task automatic issue(input bit wr, input int cs, input int a, input int d);
      req_valid = 1'b1; req_write = wr; req_cs = CS_W'(cs);
      req_addr = ADDR_W'(a); req_wdata = DATA_W'(d);
      while (!ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_idle();
      while (!ready) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      // cs0: write 1/3, cs 0/4, len 4; read 2/3, cs 0/5, len 5, float 1
      set_cfg(0, 1, 3, 0, 4, 2, 3, 0, 5, 4, 5, 1);
      // cs1 (R7 clipping, R11 separate fields): pulses exceed length;
      // read length 0 (taken as 1) with read setup 1, so no read strobe
      set_cfg(1, 2, 9, 1, 9, 1, 2, 0, 1, 5, 0, 0);
      repeat (3) @(negedge clk);
      // R1: reset values
      chk("R1", "cs_n", int'(mem_cs_n), 3);
      chk("R1", "we_n/oe_n", int'({mem_we_n, mem_oe_n}), 3);
      chk("R1", "done/dout_en", int'({done, mem_dout_en}), 0);
      chk("R1", "ready", int'(ready), 1);
      chk("R1", "rdata", int'(rdata), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 R5 R6 R10: plain write on cs0
      issue(1'b1, 0, 16'h1234, 16'hBEEF);
      wait_idle();
      // R4 R8 R9: read on cs0 with float turnaround
      issue(1'b0, 0, 16'h0042, 0);
      wait_idle();
      // R2: request raised while busy, dropped before idle, must be ignored
      issue(1'b1, 0, 16'h0a0a, 16'h5555);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_cs = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      wait_idle();
      // R7 R11: clipped write on cs1
      issue(1'b1, 1, 16'h7777, 16'hA5A5);
      wait_idle();
      // R8: zero-length read on cs1, strobe never asserts, rdata kept
      issue(1'b0, 1, 16'h0003, 0);
      wait_idle();
      // R8 R7: read on cs0 whose read pulse runs past its length
      set_cfg(0, 1, 3, 0, 4, 3, 8, 1, 9, 4, 5, 2);
      issue(1'b0, 0, 16'h0100, 0);
      wait_idle();
      // R12: back-to-back requests held valid across completion
      set_cfg(0, 0, 1, 0, 2, 0, 2, 0, 2, 2, 3, 0);
      req_valid = 1'b1; req_cs = 1'b0;
      for (int i = 0; i < 6; i++) begin
         req_write = i[0]; req_addr = ADDR_W'(16 * i); req_wdata = DATA_W'(i * 3 + 1);
         @(negedge clk);
         while (!ready) @(negedge clk);
      end
      @(negedge clk);
      req_valid = 1'b0;
      wait_idle();
      // mixed chip selects back to back (R11)
      issue(1'b0, 1, 16'h0011, 0);
      issue(1'b1, 0, 16'h0022, 16'h3C3C);
      issue(1'b1, 1, 16'h0033, 16'hC3C3);
      wait_idle();
      repeat (4) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule